// File: doc/BRIEF.md
# Battery Pack Power-Mode Controller

This block decides whether a single-cell battery monitor is awake or asleep. When it is awake, the measurement and protection logic is enabled. When it is asleep, that logic stops. The block also lets the pack-plus node be pulled down, so that a charger plugged in later can be seen cleanly. After reset it starts in sleep.

It takes several inputs:
- three asynchronous pin levels: the host data line, an active-low power switch and a charger-present comparator output;
- a cell-undervoltage event that has already been qualified upstream;
- a one-cycle pulse that marks a completed pack-swap command;
- two control bits: a disconnect-mode enable (`pmod`) and a swap-control enable (`swen`).

Going to sleep has three causes:
- a disconnect: the data line stays low for a set time while `pmod` is set;
- a cell-depletion event;
- a swap command while `swen` is set.

Waking up has four causes:
- pack reconnection;
- a press of the power switch;
- a charger appearing;
- a swap command while `swen` is set.

The disconnect time is measured by a prescaled counter. Two parameters set it: `TICK_DIV` clock cycles make one tick, and `DISC_TICKS` ticks make the disconnect time. The defaults give 2 s at a 32.768 kHz clock.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `active` is 0 (sleep).
- R2: In active mode with `pmod`=1, a synchronized low level on `dq_pin` held for `TICK_DIV*DISC_TICKS` cycles puts the block to sleep. It does not sleep earlier.
- R3: The disconnect count restarts whenever the synchronized data line is high or `pmod`=0. With `pmod`=0, a data line held low never causes sleep.
- R4: In active mode, a pulse on `uv_evt` causes sleep on the next clock edge.
- R5: In active mode, a `swap_done` pulse with `swen`=1 causes sleep on the next edge. With `swen`=0 the pulse has no effect.
- R6: In sleep, a `swap_done` pulse with `swen`=1 wakes the block on the next edge.
- R7: In sleep, `pmod`=1 together with `swen`=0 and a high synchronized data line wakes the block. Either `pmod`=0 or `swen`=1 blocks this wake.
- R8: In sleep, a low synchronized `ps_n_pin` wakes the block, whatever the value of `swen`.
- R9: In sleep, a high synchronized `chg_pin` wakes the block only when `swen`=0.
- R10: `pls_pd_en` is 1 exactly when the block is asleep and `swen`=0. It is 0 in active mode.
- R11: Simultaneous causes leave the state unchanged, in two cases:
  - in active mode, a sleep cause in a cycle where the synchronized power switch is pressed;
  - in sleep, a wake cause in a cycle where `uv_evt` is high.
- R12: `dq_pin`, `ps_n_pin` and `chg_pin` each pass through two flops. A pin change reaches `active` on the third rising edge after it and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| dq_pin | input | 1 | Host data line level (asynchronous) |
| ps_n_pin | input | 1 | Power switch sense, low = pressed (asynchronous) |
| chg_pin | input | 1 | Charger-present comparator, high = pack-plus above cell (asynchronous) |
| uv_evt | input | 1 | Qualified cell undervoltage event |
| swap_done | input | 1 | One-cycle pulse at the end of a swap command |
| pmod | input | 1 | Disconnect-mode enable bit |
| swen | input | 1 | Swap-control enable bit |
| active | output | 1 | 1 = active mode, enables measurement and protection |
| pls_pd_en | output | 1 | Enables the pack-plus discharge pulldown |

## Verification
The bench builds the block with `TICK_DIV`=4 and `DISC_TICKS`=5, so a disconnect takes 20 counted cycles. That short window keeps the disconnect threshold in reach. The bench can check both sides of it, a cycle bound just before the threshold and one just after. It can also check that a brief high pulse on the data line restarts the count. With the default parameters, these cases would take tens of thousands of cycles each. The three-edge synchronizer latency and the two simultaneous-cause cases are checked at exact clock edges.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic {
        PM_SLEEP  = 1'b0,
        PM_ACTIVE = 1'b1
    } pm_state_e;

    // Synchronized pin levels, already converted to active-high meaning.
    typedef struct packed {
        logic dq_high;
        logic sw_pressed;
        logic chg_present;
    } pin_lvl_t;

    // Raw pin vector order: {dq_pin, ps_n_pin, chg_pin}
    localparam int unsigned PIN_W = 3;
    localparam logic [PIN_W-1:0] PIN_RST = 3'b010;

    typedef struct packed {
        logic uv;
        logic disc;
        logic swap;
    } sleep_req_t;

    typedef struct packed {
        logic connect;
        logic sw;
        logic chg;
        logic swap;
    } wake_req_t;

    function automatic pin_lvl_t decode_pins(input logic [PIN_W-1:0] raw);
        pin_lvl_t l;
        l.dq_high     = raw[2];
        l.sw_pressed  = ~raw[1];
        l.chg_present = raw[0];
        return l;
    endfunction

    function automatic logic any_sleep(input sleep_req_t r);
        return r.uv | r.disc | r.swap;
    endfunction

    function automatic logic any_wake(input wake_req_t r);
        return r.connect | r.sw | r.chg | r.swap;
    endfunction

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1;
        logic s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/pm_disc_timer.sv
module pm_disc_timer #(
    parameter int unsigned TICK_DIV   = 32768,
    parameter int unsigned DISC_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int unsigned TW = $clog2(DISC_TICKS + 1);
    localparam logic [TW-1:0] T_LIM = TW'(DISC_TICKS);

    logic          tick;
    logic [TW-1:0] tcnt;

    if (TICK_DIV > 1) begin : g_pre
        localparam logic [PW-1:0] P_LAST = PW'(TICK_DIV - 1);
        logic [PW-1:0] pcnt;
        always_ff @(posedge clk) begin
            if (rst || !run)       pcnt <= '0;
            else if (pcnt == P_LAST) pcnt <= '0;
            else                   pcnt <= pcnt + 1'b1;
        end
        assign tick = run && (pcnt == P_LAST);
    end else begin : g_nopre
        assign tick = run;
    end

    always_ff @(posedge clk) begin
        if (rst || !run)              tcnt <= '0;
        else if (tick && tcnt != T_LIM) tcnt <= tcnt + 1'b1;
    end

    assign expired = (tcnt == T_LIM);
endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_lvl_t  lvl,
    input  logic      uv_evt,
    input  logic      swap_done,
    input  logic      pmod,
    input  logic      swen,
    input  logic      disc,
    output pm_state_e state
);
    sleep_req_t sreq;
    wake_req_t  wreq;
    pm_state_e  nxt;

    always_comb begin
        sreq.uv      = uv_evt;
        sreq.disc    = pmod & disc;
        sreq.swap    = swap_done & swen;
        wreq.connect = pmod & ~swen & lvl.dq_high;
        wreq.sw      = lvl.sw_pressed;
        wreq.chg     = lvl.chg_present & ~swen;
        wreq.swap    = swap_done & swen;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PM_ACTIVE: if (any_sleep(sreq) && !lvl.sw_pressed) nxt = PM_SLEEP;
            PM_SLEEP:  if (any_wake(wreq) && !uv_evt)          nxt = PM_ACTIVE;
            default:   nxt = PM_SLEEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PM_SLEEP;
        else     state <= nxt;
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int unsigned TICK_DIV   = 32768,
    parameter int unsigned DISC_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dq_pin,
    input  logic ps_n_pin,
    input  logic chg_pin,
    input  logic uv_evt,
    input  logic swap_done,
    input  logic pmod,
    input  logic swen,
    output logic active,
    output logic pls_pd_en
);
    logic [PIN_W-1:0] raw_s;
    pin_lvl_t         lvl_s;
    logic             disc;
    logic             disc_run;
    pm_state_e        state;

    pm_sync #(.W(PIN_W), .RST_VAL(PIN_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({dq_pin, ps_n_pin, chg_pin}),
        .q   (raw_s)
    );

    assign lvl_s = decode_pins(raw_s);

    // Count only while awake, in disconnect mode, with the line low.
    assign disc_run = (state == PM_ACTIVE) && pmod && !lvl_s.dq_high;

    pm_disc_timer #(.TICK_DIV(TICK_DIV), .DISC_TICKS(DISC_TICKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (disc_run),
        .expired (disc)
    );

    pm_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .lvl       (lvl_s),
        .uv_evt    (uv_evt),
        .swap_done (swap_done),
        .pmod      (pmod),
        .swen      (swen),
        .disc      (disc),
        .state     (state)
    );

    assign active    = (state == PM_ACTIVE);
    assign pls_pd_en = (state == PM_SLEEP) && !swen;
endmodule

// File: rtl/pm_checker.sv
module pm_checker
    import pwr_mode_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     active,
    input logic     pls_pd_en,
    input logic     uv_evt,
    input logic     swap_done,
    input logic     pmod,
    input logic     swen,
    input pin_lvl_t lvl
);
    p_reset_sleep_r1: assert property (@(posedge clk) rst |=> !active);

    p_active_no_pd_r10: assert property (@(posedge clk) disable iff (rst)
        active |-> !pls_pd_en);

    p_sleep_pd_r10: assert property (@(posedge clk) disable iff (rst)
        (!active && !swen) |-> pls_pd_en);

    p_uv_sleep_r4: assert property (@(posedge clk) disable iff (rst)
        (active && uv_evt && !lvl.sw_pressed) |=> !active);

    p_swap_sleep_r5: assert property (@(posedge clk) disable iff (rst)
        (active && swap_done && swen && !lvl.sw_pressed) |=> !active);

    p_sw_wake_r8: assert property (@(posedge clk) disable iff (rst)
        (!active && lvl.sw_pressed && !uv_evt) |=> active);

    p_chg_wake_r9: assert property (@(posedge clk) disable iff (rst)
        (!active && lvl.chg_present && !swen && !uv_evt) |=> active);

    p_hold_active_r11: assert property (@(posedge clk) disable iff (rst)
        (active && lvl.sw_pressed) |=> active);

    p_nodisc_r3: assert property (@(posedge clk) disable iff (rst)
        (active && !pmod && !uv_evt && !(swap_done && swen)) |=> active);
endmodule

bind pwr_mode_ctrl pm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .pls_pd_en (pls_pd_en),
    .uv_evt    (uv_evt),
    .swap_done (swap_done),
    .pmod      (pmod),
    .swen      (swen),
    .lvl       (lvl_s)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV = 4;
    localparam int DTICKS = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dq_pin = 1'b1, ps_n_pin = 1'b1, chg_pin = 1'b0;
    logic uv_evt = 1'b0, swap_done = 1'b0, pmod = 1'b0, swen = 1'b0;
    logic active, pls_pd_en;
    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl #(.TICK_DIV(TDIV), .DISC_TICKS(DTICKS)) u0 (
        .clk(clk), .rst(rst), .dq_pin(dq_pin), .ps_n_pin(ps_n_pin),
        .chg_pin(chg_pin), .uv_evt(uv_evt), .swap_done(swap_done),
        .pmod(pmod), .swen(swen), .active(active), .pls_pd_en(pls_pd_en)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    task automatic wake_by_switch();
        ps_n_pin = 1'b0; step(4);
        ps_n_pin = 1'b1; step(3);
    endtask

    task automatic sleep_by_uv();
        uv_evt = 1'b1; step(1);
        uv_evt = 1'b0; step(1);
    endtask

    task automatic t_reset();
        step(2);
        chk(active, 1'b0, "R1", "active during reset");
        rst = 1'b0; step(1);
        chk(active, 1'b0, "R1", "active after reset");
        chk(pls_pd_en, 1'b1, "R10", "pulldown in sleep swen=0");
        swen = 1'b1; step(1);
        chk(pls_pd_en, 1'b0, "R10", "pulldown in sleep swen=1");
        swen = 1'b0; step(1);
    endtask

    task automatic t_sync_latency();
        ps_n_pin = 1'b0; step(2);
        chk(active, 1'b0, "R12", "active after two edges");
        step(1);
        chk(active, 1'b1, "R12", "active after third edge");
        chk(pls_pd_en, 1'b0, "R10", "pulldown while active");
        ps_n_pin = 1'b1; step(3);
    endtask

    task automatic t_uv();
        uv_evt = 1'b1; step(1);
        uv_evt = 1'b0;
        chk(active, 1'b0, "R4", "sleep after undervoltage");
    endtask

    task automatic t_swap();
        wake_by_switch();
        swen = 1'b0; swap_done = 1'b1; step(1);
        swap_done = 1'b0; step(1);
        chk(active, 1'b1, "R5", "swap ignored with swen=0");
        swen = 1'b1; swap_done = 1'b1; step(1);
        swap_done = 1'b0;
        chk(active, 1'b0, "R5", "swap sleeps with swen=1");
        step(2);
        chk(active, 1'b0, "R6", "stays asleep before swap");
        swap_done = 1'b1; step(1);
        swap_done = 1'b0;
        chk(active, 1'b1, "R6", "swap wakes with swen=1");
        swen = 1'b0; sleep_by_uv();
    endtask

    task automatic t_connect();
        dq_pin = 1'b1; pmod = 1'b0; step(4);
        chk(active, 1'b0, "R7", "no connect wake with pmod=0");
        pmod = 1'b1; swen = 1'b1; step(3);
        chk(active, 1'b0, "R7", "no connect wake with swen=1");
        swen = 1'b0; step(1);
        chk(active, 1'b1, "R7", "connect wake");
    endtask

    task automatic t_disconnect();
        // active, pmod=1, swen=0
        dq_pin = 1'b0; step(18);
        chk(active, 1'b1, "R2", "awake before disconnect time");
        step(10);
        chk(active, 1'b0, "R2", "asleep after disconnect time");
        wake_by_switch();
        dq_pin = 1'b1; step(3);
        dq_pin = 1'b0; step(15);
        dq_pin = 1'b1; step(3);
        dq_pin = 1'b0; step(18);
        chk(active, 1'b1, "R3", "count restarted by high line");
        step(10);
        chk(active, 1'b0, "R3", "sleep after restarted count");
        pmod = 1'b0;
        wake_by_switch();
        step(40);
        chk(active, 1'b1, "R3", "no disconnect with pmod=0");
        dq_pin = 1'b1;
        sleep_by_uv();
    endtask

    task automatic t_switch_swen();
        swen = 1'b1; step(1);
        ps_n_pin = 1'b0; step(3);
        chk(active, 1'b1, "R8", "switch wakes with swen=1");
        ps_n_pin = 1'b1; step(3);
        swen = 1'b0; sleep_by_uv();
    endtask

    task automatic t_charger();
        swen = 1'b1; chg_pin = 1'b1; step(5);
        chk(active, 1'b0, "R9", "no charger wake with swen=1");
        swen = 1'b0; step(1);
        chk(active, 1'b1, "R9", "charger wake with swen=0");
        chg_pin = 1'b0; step(3);
        sleep_by_uv();
    endtask

    task automatic t_conflict();
        wake_by_switch();
        ps_n_pin = 1'b0; step(3);
        swen = 1'b1; swap_done = 1'b1; step(1);
        swap_done = 1'b0;
        chk(active, 1'b1, "R11", "swap blocked by pressed switch");
        uv_evt = 1'b1; step(1);
        uv_evt = 1'b0;
        chk(active, 1'b1, "R11", "undervoltage blocked by pressed switch");
        ps_n_pin = 1'b1; step(3);
        sleep_by_uv();
        chg_pin = 1'b1; step(3);
        swen = 1'b0; uv_evt = 1'b1; step(1);
        uv_evt = 1'b0;
        chk(active, 1'b0, "R11", "charger wake blocked by undervoltage");
        step(1);
        chk(active, 1'b1, "R11", "charger wake after undervoltage clears");
        chg_pin = 1'b0; step(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_sync_latency();
        t_uv();
        t_swap();
        t_connect();
        t_disconnect();
        t_switch_swen();
        t_charger();
        t_conflict();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule